// File: doc/BRIEF.md
# Daisy-Chain Setting Host Controller

This block is the host side of a serial link to a chain of `N_DEV` setting devices. The devices are wired in a daisy chain. Each device holds a 17-bit setting word made of a select bit and two 8-bit level codes. The link has three lines: a frame enable (`chain_rst`), a shift clock (`chain_clk`) and a shared data line. The data line is split into a drive value, an output enable and a sampled input. The cascade output of the last device is looped back onto the data line through a weak path, so the line carries that bit whenever the host is not driving.

A command is accepted with a valid/ready handshake. It carries a read/write flag, a half-period for the shift clock, and `17*N_DEV` bits of packed frames.
- A write drives the frames out, most significant bit first, while the frame enable is high. It then lowers the frame enable so that the devices take the new settings.
- A read never drives the data line. It samples the bit that circulates back from the chain: once before the frame enable rises, and then once before each later rising clock. After `17*N_DEV` clocks every device again holds what it held before. The captured word is returned on a response handshake in the same packing as a write.

Top module: `chc_chain_host`

## Requirements
- R1: A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is high only while the block is idle (`busy` low). A command presented while busy has no effect on the transfer in flight or on the device settings.
- R2: Every transaction produces exactly `17*N_DEV` rising edges on `chain_clk`, all while `chain_rst` is high. `chain_clk` never rises while `chain_rst` is low.
- R3: While `chain_rst` is high, each high phase and each low phase of `chain_clk` lasts max(`cmd_half`,1) system clock cycles. A `cmd_half` of 0 behaves as 1.
- R4: A write sends `cmd_frames` most significant bit first. Device k (k=0 nearest the host) receives `cmd_frames[17k+16:17k]`, so the frame of the last device goes out first. Within a frame, bit 16 is the select bit, bits 15:8 are the first level code and bits 7:0 are the second level code; each code goes out MSB first.
- R5: During a write, `dq_drive` changes only while `chain_clk` is low. It stays constant through every high phase.
- R6: During a read, `dq_oe` stays low for the whole transaction.
- R7: A read samples `dq_in` once while `chain_rst` is still low, just before raising it, and then once at the end of each later low phase. `rsp_frames` then holds the circulated word in the packing of R4. The device settings after a read equal those before it.
- R8: `chain_clk` is low in every cycle in which `chain_rst` changes. A transaction ends by lowering `chain_rst` after a full low phase of `chain_clk`.
- R9: After a read, `rsp_valid` stays high with `rsp_frames` stable until `rsp_ready` is seen. `done` is a one-cycle pulse: after a write it coincides with `chain_rst` falling, and after a read it coincides with the response handshake.
- R10: During and right after reset, `chain_rst`, `chain_clk`, `dq_oe`, `busy`, `rsp_valid` and `done` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_read | input | 1 | 1 = non-destructive read, 0 = write |
| cmd_half | input | DIV_W | Shift-clock half period in system cycles (0 acts as 1) |
| cmd_frames | input | 17*N_DEV | Packed frames to write |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Read result taken |
| rsp_frames | output | 17*N_DEV | Packed frames captured by a read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| chain_rst | output | 1 | Frame enable to the chain |
| chain_clk | output | 1 | Shift clock to the chain |
| dq_drive | output | 1 | Value driven onto the data line |
| dq_oe | output | 1 | Data line drive enable |
| dq_in | input | 1 | Sampled level of the data line |

## Verification
The bench builds the block with two chained devices and a 4-bit half-period field, so a full transfer is 34 bits. Both the order between frames and the order within a frame can be seen, and a swap between device slots shows up as wrong settings. Half periods from 0 up to 5 cover the divider's floor value and several phase lengths. A read straight after power-up returns the mid-scale default from both devices, and write-then-read pairs with random words show that the loopback returns the written frames.

// File: rtl/chc_pkg.sv
package chc_pkg;
    localparam int FRAME_BITS = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_STOP,
        ST_RESP
    } chc_state_e;
endpackage

// File: rtl/chc_half_timer.sv
// Phase timer: expires once every max(len,1) cycles while run is high.
module chc_half_timer #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] len_i,
    input  logic             run_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] reload;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.reload = (len_i == '0) ? '0 : len_i - 1'b1;
            tmr_d.cnt    = tmr_d.reload;
        end else if (run_i) begin
            tmr_d.cnt = (tmr_q.cnt == '0) ? tmr_q.reload : tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expire_o = run_i && !load_i && (tmr_q.cnt == '0);

    // R3: a running count never exceeds its reload value
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= tmr_q.reload);
endmodule

// File: rtl/chc_frame_shifter.sv
// Shared shift register: sends the write word out of its MSB, collects read bits at its LSB.
module chc_frame_shifter #(
    parameter int WIDTH = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] data_o,
    output logic             msb_o
);
    logic [WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i)       sh_d = load_val_i;
        else if (shift_i) sh_d = {sh_q[WIDTH-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign data_o = sh_q;
    assign msb_o  = sh_q[WIDTH-1];

    // R7: with no load or shift the word holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && !shift_i |=> $stable(sh_q));
endmodule

// File: rtl/chc_chain_host.sv
module chc_chain_host
    import chc_pkg::*;
#(
    parameter int N_DEV = 2,
    parameter int DIV_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic                        cmd_read,
    input  logic [DIV_W-1:0]            cmd_half,
    input  logic [FRAME_BITS*N_DEV-1:0] cmd_frames,
    output logic                        rsp_valid,
    input  logic                        rsp_ready,
    output logic [FRAME_BITS*N_DEV-1:0] rsp_frames,
    output logic                        busy,
    output logic                        done,
    output logic                        chain_rst,
    output logic                        chain_clk,
    output logic                        dq_drive,
    output logic                        dq_oe,
    input  logic                        dq_in
);
    localparam int W     = FRAME_BITS * N_DEV;
    localparam int IDX_W = $clog2(W + 1);

    typedef struct packed {
        chc_state_e       st;
        logic             rd;
        logic [IDX_W-1:0] idx;
        logic             crst;
        logic             cclk;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic         tmr_load, tmr_run, tmr_expire;
    logic         sh_load, sh_shift, sh_bit, sh_msb;
    logic [W-1:0] sh_load_val, sh_data;

    chc_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .len_i    (cmd_half),
        .run_i    (tmr_run),
        .expire_o (tmr_expire)
    );

    chc_frame_shifter #(.WIDTH(W)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (sh_load_val),
        .shift_i    (sh_shift),
        .bit_i      (sh_bit),
        .data_o     (sh_data),
        .msb_o      (sh_msb)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        tmr_load    = 1'b0;
        sh_load     = 1'b0;
        sh_load_val = cmd_read ? '0 : cmd_frames;
        sh_shift    = 1'b0;
        sh_bit      = 1'b0;
        tmr_run     = (ctl_q.st == ST_START) || (ctl_q.st == ST_LOW) ||
                      (ctl_q.st == ST_HIGH)  || (ctl_q.st == ST_STOP);
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    tmr_load   = 1'b1;
                    sh_load    = 1'b1;
                    ctl_d.st   = ST_START;
                    ctl_d.rd   = cmd_read;
                    ctl_d.idx  = '0;
                    ctl_d.crst = 1'b0;
                    ctl_d.cclk = 1'b0;
                end
            end
            ST_START: begin
                if (tmr_expire) begin
                    ctl_d.crst = 1'b1;
                    ctl_d.st   = ST_LOW;
                    if (ctl_q.rd) begin
                        sh_shift = 1'b1;
                        sh_bit   = dq_in;
                    end
                end
            end
            ST_LOW: begin
                if (tmr_expire) begin
                    ctl_d.cclk = 1'b1;
                    ctl_d.st   = ST_HIGH;
                    if (ctl_q.rd && (ctl_q.idx != '0)) begin
                        sh_shift = 1'b1;
                        sh_bit   = dq_in;
                    end
                end
            end
            ST_HIGH: begin
                if (tmr_expire) begin
                    ctl_d.cclk = 1'b0;
                    if (!ctl_q.rd) sh_shift = 1'b1;
                    if (ctl_q.idx == IDX_W'(W - 1)) begin
                        ctl_d.st = ST_STOP;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                        ctl_d.st  = ST_LOW;
                    end
                end
            end
            ST_STOP: begin
                if (tmr_expire) begin
                    ctl_d.crst = 1'b0;
                    if (ctl_q.rd) begin
                        ctl_d.st = ST_RESP;
                    end else begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end
            end
            ST_RESP: begin
                if (rsp_ready) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_ready  = (ctl_q.st == ST_IDLE);
    assign busy       = (ctl_q.st != ST_IDLE);
    assign rsp_valid  = (ctl_q.st == ST_RESP);
    assign rsp_frames = sh_data;
    assign done       = ctl_q.done;
    assign chain_rst  = ctl_q.crst;
    assign chain_clk  = ctl_q.cclk;
    assign dq_oe      = busy && (ctl_q.st != ST_RESP) && !ctl_q.rd;
    assign dq_drive   = dq_oe && sh_msb;

    // Edge counter used only by the checks below
    logic [IDX_W:0] rise_cnt_q;
    logic           clk_prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt_q <= '0;
            clk_prev_q <= 1'b0;
        end else begin
            clk_prev_q <= chain_clk;
            if (!chain_rst)                    rise_cnt_q <= '0;
            else if (chain_clk && !clk_prev_q) rise_cnt_q <= rise_cnt_q + 1'b1;
        end
    end

    p_edge_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chain_rst) |-> rise_cnt_q == (IDX_W+1)'(W));
    p_rise_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_clk) |-> chain_rst);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !chain_clk && !rsp_valid);
    p_dq_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chain_clk |-> $stable(dq_drive));
    p_rst_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chain_rst) |-> !chain_clk);
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_frames));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_read_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !dq_oe && !chain_rst);
endmodule

// File: tb/tb_chc_chain_host.sv
module tb_chc_chain_host;
    localparam int N_DEV = 2;
    localparam int DIV_W = 4;
    localparam int W     = 17 * N_DEV;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cmd_valid, cmd_ready, cmd_read;
    logic [DIV_W-1:0] cmd_half;
    logic [W-1:0]     cmd_frames, rsp_frames;
    logic             rsp_valid, rsp_ready, busy, done;
    logic             chain_rst, chain_clk, dq_drive, dq_oe, dq_in;

    always #10 clk = ~clk;

    chc_chain_host #(.N_DEV(N_DEV), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_read(cmd_read), .cmd_half(cmd_half), .cmd_frames(cmd_frames),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_frames(rsp_frames),
        .busy(busy), .done(done), .chain_rst(chain_rst), .chain_clk(chain_clk),
        .dq_drive(dq_drive), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // Two behavioural chained devices with the cascade looped back onto the data line
    logic [16:0] dev_sr [N_DEV];
    logic [16:0] dev_set [N_DEV];
    initial begin
        for (int k = 0; k < N_DEV; k++) begin
            dev_sr[k]  = 17'h08080;
            dev_set[k] = 17'h08080;
        end
    end
    assign dq_in = dq_oe ? dq_drive : dev_sr[N_DEV-1][16];
    always @(posedge chain_clk) begin
        if (chain_rst) begin
            dev_sr[0] <= {dev_sr[0][15:0], dq_in};
            for (int k = 1; k < N_DEV; k++) dev_sr[k] <= {dev_sr[k][15:0], dev_sr[k-1][16]};
        end
    end
    always @(negedge chain_rst) begin
        for (int k = 0; k < N_DEV; k++) dev_set[k] <= dev_sr[k];
    end

    int tests = 0, fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Link monitor sampled on the falling system clock
    int   rise_seen, phase_bad, dq_bad, oe_bad, rstedge_bad, run_len, exp_half;
    bit   cur_rd, run_in_frame;
    logic p_clk = 1'b0, p_rst = 1'b0, p_dq = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (chain_clk && !p_clk && chain_rst) rise_seen++;
            if (chain_clk != p_clk || chain_rst != p_rst) begin
                if (chain_clk != p_clk && chain_rst && p_rst && run_in_frame && run_len != exp_half)
                    phase_bad++;
                run_len      = 1;
                run_in_frame = chain_rst;
            end else begin
                run_len++;
            end
            if (chain_rst != p_rst && (chain_clk || p_clk)) rstedge_bad++;
            if (dq_oe && chain_clk && p_clk && dq_drive != p_dq) dq_bad++;
            if (cur_rd && dq_oe) oe_bad++;
            p_clk = chain_clk;
            p_rst = chain_rst;
            p_dq  = dq_drive;
        end
    end

    function automatic logic [16:0] exp_dev(input logic [W-1:0] fr, input int k);
        return fr[17*k +: 17];
    endfunction

    task automatic run_cmd(input bit rd, input logic [DIV_W-1:0] half, input logic [W-1:0] fr,
                           input int hold, input bit inject, output logic [W-1:0] got);
        rise_seen = 0; phase_bad = 0; dq_bad = 0; oe_bad = 0; rstedge_bad = 0;
        cur_rd = rd; exp_half = (half == 0) ? 1 : int'(half);
        got = '0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_read = rd; cmd_half = half; cmd_frames = fr;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready && busy, "R1", "ready/busy during transfer", {cmd_ready, busy}, 2'b01);
        if (inject) begin
            cmd_valid = 1'b1; cmd_read = 1'b0; cmd_frames = ~fr; cmd_half = 4'd1;
            repeat (6) @(negedge clk);
            cmd_valid = 1'b0;
        end
        if (!rd) begin
            while (!done) @(negedge clk);
            check(!chain_rst, "R9", "done with frame enable low", chain_rst, 0);
            @(negedge clk);
            check(!done, "R9", "done single cycle", done, 0);
        end else begin
            while (!rsp_valid) @(negedge clk);
            got = rsp_frames;
            repeat (hold) @(negedge clk);
            check(rsp_valid && rsp_frames == got, "R9", "response held", rsp_valid, 1);
            rsp_ready = 1'b1;
            @(negedge clk);
            rsp_ready = 1'b0;
            check(done && !rsp_valid, "R9", "done at handshake", done, 1);
            check(oe_bad == 0, "R6", "drive enabled during read", oe_bad, 0);
        end
        check(rise_seen == W, "R2", "rising edges", rise_seen, W);
        check(phase_bad == 0, "R3", "phase length errors", phase_bad, 0);
        check(dq_bad == 0, "R5", "data moved in high phase", dq_bad, 0);
        check(rstedge_bad == 0, "R8", "enable edge with clock high", rstedge_bad, 0);
        cur_rd = 1'b0;
    endtask

    task automatic check_settings(input logic [W-1:0] fr, input string req);
        for (int k = 0; k < N_DEV; k++)
            check(dev_set[k] == exp_dev(fr, k), req, "device setting", dev_set[k], exp_dev(fr, k));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] got, fr, start_val;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0; cmd_half = '0;
        cmd_frames = '0; rsp_ready = 1'b0; cur_rd = 1'b0;
        repeat (3) @(negedge clk);
        check({chain_rst, chain_clk, dq_oe, busy, rsp_valid, done, cmd_ready} == 7'b0000001,
              "R10", "outputs in reset", {chain_rst, chain_clk, dq_oe, busy, rsp_valid, done, cmd_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check({chain_rst, chain_clk, dq_oe, busy, rsp_valid, done, cmd_ready} == 7'b0000001,
              "R10", "outputs after reset", {chain_rst, chain_clk, dq_oe, busy, rsp_valid, done, cmd_ready}, 1);

        // R7: read of the power-up contents
        start_val = {N_DEV{17'h08080}};
        run_cmd(1'b1, 4'd2, '0, 0, 1'b0, got);
        check(got == start_val, "R7", "power-up read", got, start_val);
        check_settings(start_val, "R7");

        // R4: directed field placement
        fr = {17'h1A53C, 17'h00FF0};
        run_cmd(1'b0, 4'd1, fr, 0, 1'b0, got);
        check(dev_set[1][16] == 1'b1 && dev_set[1][15:8] == 8'hA5 && dev_set[1][7:0] == 8'h3C,
              "R4", "last device fields", dev_set[1], 17'h1A53C);
        check(dev_set[0][16] == 1'b0 && dev_set[0][15:8] == 8'h0F && dev_set[0][7:0] == 8'hF0,
              "R4", "first device fields", dev_set[0], 17'h00FF0);

        run_cmd(1'b1, 4'd3, '0, 2, 1'b0, got);
        check(got == fr, "R7", "read after write", got, fr);
        check_settings(fr, "R7");

        // R3: zero half period acts as one
        run_cmd(1'b1, 4'd0, '0, 0, 1'b0, got);
        check(got == fr, "R7", "read at fastest rate", got, fr);

        // R1: command offered while busy is ignored
        fr = {17'h0C3A5, 17'h15A0F};
        run_cmd(1'b0, 4'd2, fr, 0, 1'b1, got);
        check_settings(fr, "R1");
        run_cmd(1'b1, 4'd1, '0, 0, 1'b0, got);
        check(got == fr, "R1", "read after ignored command", got, fr);

        // Random write/read pairs
        for (int i = 0; i < 8; i++) begin
            logic [DIV_W-1:0] h;
            fr = W'({$urandom, $urandom});
            h  = DIV_W'($urandom_range(1, 5));
            run_cmd(1'b0, h, fr, 0, 1'b0, got);
            check_settings(fr, "R4");
            run_cmd(1'b1, DIV_W'($urandom_range(0, 5)), '0, $urandom_range(0, 3), 1'b0, got);
            check(got == fr, "R7", "random read back", got, fr);
            check_settings(fr, "R7");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule